// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block holds the privileged control state of a simple 32-bit processor and sequences entry into and exit from exception handlers. Each cycle it looks at the instruction in the exception stage and at the external interrupt lines. Pending requests are a TLB refill, another address fault, a privilege violation, a system call or an interrupt. When it takes one, it records where to restart, why it stopped and, for address faults, which address failed. It then switches the core to kernel mode with interrupts masked and sends fetch to a handler entry point.

A return request in kernel mode undoes the entry in one step: it re-enables interrupts, drops back to user mode and sends fetch to the saved restart address. Handler software can read the three privileged registers through a small read port. That port works only in kernel mode. A user-mode read, or a user-mode return, is turned into a privilege exception. Interrupts are reported against the instruction currently in the exception stage, so every exception is precise.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On every taken exception, the saved restart register (EPC) is loaded with `inst_pc` of that cycle. An interrupt uses the PC of the instruction it is attached to.
- R2: On every taken exception, the next state is kernel mode (`kernel_mode`=1) with interrupts masked (`irq_enable`=0), both visible one cycle after the request.
- R3: The cause register holds the exception code in bits [6:2]. The codes are: interrupt 0, refill on load 2, refill on store 3, address fault on load 4, address fault on store 5, system call 8, privilege violation 11. For an interrupt, bits [8+k] hold the sampled state of line k; all other bits read 0.
- R4: The bad-address register loads `fault_va` only when a TLB refill or address fault is taken. Any other event leaves it unchanged.
- R5: One cycle after a taken exception, `redirect_valid` pulses high for one cycle. `redirect_pc` is 0x8000_0000 for a TLB refill and 0x8000_0180 for every other exception.
- R6: `eret_req` in kernel mode with no exception taken sets user mode and `irq_enable`=1, and redirects to EPC, one cycle later.
- R7: In kernel mode, `csr_rd_data` is combinational from `csr_rd_sel`: 0 selects EPC, 1 selects cause, 2 selects bad address, and 3 reads 0. In user mode it reads 0, and `csr_rd_en` raises a privilege violation (code 11).
- R8: `eret_req` in user mode does not return. It raises a privilege violation with the general vector.
- R9: `syscall_req` enters kernel mode through the general vector with code 8.
- R10: While `irq_enable` is 0, interrupt lines are ignored: no redirect, no state change. While it is 1, any active line is taken with code 0.
- R11: Simultaneous requests resolve in this order, highest first: TLB refill, address fault, privilege violation, system call, interrupt. Any taken exception overrides a same-cycle return.
- R12: Reset gives kernel mode, interrupts masked, no redirect, and EPC, cause and bad address all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inst_pc | input | 32 | PC of the instruction in the exception stage |
| fault_va | input | 32 | Faulting virtual address for refill or address faults |
| tlb_refill_req | input | 1 | TLB refill request from the instruction |
| addr_fault_req | input | 1 | Non-refill address fault from the instruction |
| fault_is_store | input | 1 | Faulting access was a store |
| syscall_req | input | 1 | Instruction is a system call |
| irq_req | input | 6 | External interrupt lines |
| eret_req | input | 1 | Instruction is an exception return |
| csr_rd_en | input | 1 | Privileged register read |
| csr_rd_sel | input | 2 | Register selector for the read |
| csr_rd_data | output | 32 | Read data |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | 32 | Fetch redirect target |
| kernel_mode | output | 1 | 1 when in kernel mode |
| irq_enable | output | 1 | 1 when interrupts are accepted |

## Verification
The assertions assume that the request inputs are steady across each rising edge and that they describe the one instruction whose PC is on `inst_pc`. They also assume that `fault_va` is meaningful only when a refill or address fault is raised. The bench changes every input at the falling edge and raises a fault address only together with a fault request. It clears all requests after each stimulus cycle, so no request is counted twice.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [4:0] {
        EXC_INT  = 5'd0,
        EXC_TLBL = 5'd2,
        EXC_TLBS = 5'd3,
        EXC_ADEL = 5'd4,
        EXC_ADES = 5'd5,
        EXC_SYS  = 5'd8,
        EXC_PRIV = 5'd11
    } exc_code_e;

    typedef enum logic [1:0] {
        SEL_EPC   = 2'd0,
        SEL_CAUSE = 2'd1,
        SEL_BAD   = 2'd2,
        SEL_NONE  = 2'd3
    } csr_sel_e;

    localparam int CODE_LSB = 2;
    localparam int IRQ_LSB  = 8;

endpackage

// File: rtl/exc_irq_gate.sv
module exc_irq_gate #(
    parameter int NIRQ = 6
) (
    input  logic [NIRQ-1:0] irq_req,
    input  logic            irq_enable,
    output logic [NIRQ-1:0] irq_masked,
    output logic            irq_any
);
    genvar g;
    generate
        for (g = 0; g < NIRQ; g++) begin : g_mask
            assign irq_masked[g] = irq_req[g] & irq_enable;
        end
    endgenerate

    assign irq_any = |irq_masked;
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic      tlbr,
    input  logic      adf,
    input  logic      is_store,
    input  logic      priv,
    input  logic      sys,
    input  logic      irq,
    output logic      take,
    output exc_code_e code,
    output logic      is_refill,
    output logic      is_addr
);
    always_comb begin
        take      = 1'b1;
        code      = EXC_INT;
        is_refill = 1'b0;
        is_addr   = 1'b0;
        if (tlbr) begin
            code      = is_store ? EXC_TLBS : EXC_TLBL;
            is_refill = 1'b1;
            is_addr   = 1'b1;
        end else if (adf) begin
            code    = is_store ? EXC_ADES : EXC_ADEL;
            is_addr = 1'b1;
        end else if (priv) begin
            code = EXC_PRIV;
        end else if (sys) begin
            code = EXC_SYS;
        end else if (irq) begin
            code = EXC_INT;
        end else begin
            take = 1'b0;
        end
    end
endmodule

// File: rtl/exc_rdport.sv
module exc_rdport
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            kernel,
    input  logic            rd_en,
    input  logic [1:0]      rd_sel,
    input  logic [XLEN-1:0] epc,
    input  logic [XLEN-1:0] cause,
    input  logic [XLEN-1:0] bad,
    output logic [XLEN-1:0] rd_data,
    output logic            viol
);
    always_comb begin
        rd_data = '0;
        if (kernel) begin
            unique case (csr_sel_e'(rd_sel))
                SEL_EPC:   rd_data = epc;
                SEL_CAUSE: rd_data = cause;
                SEL_BAD:   rd_data = bad;
                default:   rd_data = '0;
            endcase
        end
    end

    assign viol = rd_en & ~kernel;
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter int          NIRQ        = 6,
    parameter logic [31:0] VEC_REFILL  = 32'h8000_0000,
    parameter logic [31:0] VEC_GENERAL = 32'h8000_0180
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] inst_pc,
    input  logic [XLEN-1:0] fault_va,
    input  logic            tlb_refill_req,
    input  logic            addr_fault_req,
    input  logic            fault_is_store,
    input  logic            syscall_req,
    input  logic [NIRQ-1:0] irq_req,
    input  logic            eret_req,
    input  logic            csr_rd_en,
    input  logic [1:0]      csr_rd_sel,
    output logic [XLEN-1:0] csr_rd_data,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic            kernel_mode,
    output logic            irq_enable
);
    localparam int CAUSE_TOP = IRQ_LSB + NIRQ;

    typedef struct packed {
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] bad;
        logic            kernel;
        logic            ie;
        logic            rv;
        logic [XLEN-1:0] rpc;
    } state_t;

    state_t s_d, s_q;

    logic [NIRQ-1:0] irq_masked;
    logic            irq_any;
    logic            rd_viol;
    logic            eret_viol;
    logic            take;
    exc_code_e       code;
    logic            is_refill;
    logic            is_addr;

    exc_irq_gate #(.NIRQ(NIRQ)) u_gate (
        .irq_req    (irq_req),
        .irq_enable (s_q.ie),
        .irq_masked (irq_masked),
        .irq_any    (irq_any)
    );

    exc_rdport #(.XLEN(XLEN)) u_rd (
        .kernel  (s_q.kernel),
        .rd_en   (csr_rd_en),
        .rd_sel  (csr_rd_sel),
        .epc     (s_q.epc),
        .cause   (s_q.cause),
        .bad     (s_q.bad),
        .rd_data (csr_rd_data),
        .viol    (rd_viol)
    );

    assign eret_viol = eret_req & ~s_q.kernel;

    exc_arbiter u_arb (
        .tlbr      (tlb_refill_req),
        .adf       (addr_fault_req),
        .is_store  (fault_is_store),
        .priv      (rd_viol | eret_viol),
        .sys       (syscall_req),
        .irq       (irq_any),
        .take      (take),
        .code      (code),
        .is_refill (is_refill),
        .is_addr   (is_addr)
    );

    always_comb begin
        s_d    = s_q;
        s_d.rv = 1'b0;
        if (take) begin
            s_d.epc                        = inst_pc;
            s_d.cause                      = '0;
            s_d.cause[CODE_LSB +: 5]       = code;
            if (code == EXC_INT) begin
                s_d.cause[IRQ_LSB +: NIRQ] = irq_masked;
            end
            if (is_addr) begin
                s_d.bad = fault_va;
            end
            s_d.kernel = 1'b1;
            s_d.ie     = 1'b0;
            s_d.rv     = 1'b1;
            s_d.rpc    = is_refill ? VEC_REFILL : VEC_GENERAL;
        end else if (eret_req && s_q.kernel) begin
            s_d.kernel = 1'b0;
            s_d.ie     = 1'b1;
            s_d.rv     = 1'b1;
            s_d.rpc    = s_q.epc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.kernel <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign redirect_valid = s_q.rv;
    assign redirect_pc    = s_q.rpc;
    assign kernel_mode    = s_q.kernel;
    assign irq_enable     = s_q.ie;

    initial begin
        assert (CAUSE_TOP <= XLEN) else $error("irq field does not fit cause");
    end

    p_epc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> s_q.epc == $past(inst_pc));

    p_entry_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> kernel_mode && !irq_enable);

    p_cause_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> s_q.cause[CODE_LSB +: 5] == $past(code));

    p_bad_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tlb_refill_req && !addr_fault_req) |=> $stable(s_q.bad));

    p_refill_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_refill_req |=> redirect_valid && redirect_pc == VEC_REFILL);

    p_eret_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_req && kernel_mode && !take) |=>
            !kernel_mode && irq_enable && redirect_pc == $past(s_q.epc));

    p_user_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !kernel_mode |-> csr_rd_data == '0);

    p_user_eret_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_req && !kernel_mode) |=> kernel_mode && redirect_pc == VEC_GENERAL);

    p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_enable && !tlb_refill_req && !addr_fault_req && !syscall_req
         && !rd_viol && !eret_viol) |-> !take);

endmodule

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/100ps
module exc_entry_ctrl_tb;
    localparam logic [31:0] VR = 32'h8000_0000;
    localparam logic [31:0] VG = 32'h8000_0180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] inst_pc = '0, fault_va = '0;
    logic        tlbr = 0, adf = 0, st = 0, sys = 0, eret = 0, rd_en = 0;
    logic [5:0]  irq = '0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_data, rpc;
    logic        rv, kmode, ie;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    exc_entry_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .inst_pc(inst_pc), .fault_va(fault_va),
        .tlb_refill_req(tlbr), .addr_fault_req(adf), .fault_is_store(st),
        .syscall_req(sys), .irq_req(irq), .eret_req(eret),
        .csr_rd_en(rd_en), .csr_rd_sel(rd_sel), .csr_rd_data(rd_data),
        .redirect_valid(rv), .redirect_pc(rpc), .kernel_mode(kmode),
        .irq_enable(ie)
    );

    typedef struct packed {
        logic        tlbr, adf, st, sys;
        logic [5:0]  irq;
        logic        eret, rd;
        logic [31:0] pc, va;
        logic        rv;
        logic [31:0] rpc;
        logic        k, ie;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        // R6 return from reset kernel to user, target EPC=0
        '{0,0,0,0,6'h00,1,0,32'h100,32'h0,        1,32'h0,  0,1},
        // R10 interrupt taken while enabled, general vector
        '{0,0,0,0,6'h04,0,0,32'h200,32'h0,        1,VG,     1,0},
        // R10 interrupt ignored while masked
        '{0,0,0,0,6'h01,0,0,32'h204,32'h0,        0,32'h0,  1,0},
        '{0,0,0,0,6'h00,1,0,32'h208,32'h0,        1,32'h200,0,1},
        // R11 R5 refill beats all others, refill vector
        '{1,1,1,1,6'h3f,0,0,32'h300,32'h12345678, 1,VR,     1,0},
        '{0,0,0,0,6'h00,1,0,32'h304,32'h0,        1,32'h300,0,1},
        // R11 address fault beats syscall
        '{0,1,0,1,6'h00,0,0,32'h400,32'hdeadbeef, 1,VG,     1,0},
        '{0,0,0,0,6'h00,1,0,32'h404,32'h0,        1,32'h400,0,1},
        // R9 syscall
        '{0,0,0,1,6'h00,0,0,32'h500,32'h0,        1,VG,     1,0},
        '{0,0,0,0,6'h00,1,0,32'h504,32'h0,        1,32'h500,0,1},
        // R8 user-mode return raises violation
        '{0,0,0,0,6'h00,1,0,32'h600,32'h0,        1,VG,     1,0},
        '{0,0,0,0,6'h00,1,0,32'h604,32'h0,        1,32'h600,0,1},
        // R7 user-mode read raises violation
        '{0,0,0,0,6'h00,0,1,32'h700,32'h0,        1,VG,     1,0},
        '{0,0,0,0,6'h00,1,0,32'h704,32'h0,        1,32'h700,0,1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        tlbr = 0; adf = 0; st = 0; sys = 0; eret = 0; rd_en = 0;
        irq = '0; fault_va = '0;
    endtask

    // drive one instruction for one cycle, then land on the next falling edge
    task automatic step();
        @(negedge clk);
        clear_in();
    endtask

    task automatic rd_chk(input string req, input logic [1:0] sel, input logic [31:0] exp);
        rd_en = 1; rd_sel = sel;
        #1;
        chk(req, rd_data, exp);
        @(negedge clk);
        rd_en = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 kernel", {31'b0, kmode}, 32'd1);
        chk("R12 ie", {31'b0, ie}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 rv", {31'b0, rv}, 32'd0);
        rd_chk("R12 epc", 2'd0, 32'h0);
        rd_chk("R12 cause", 2'd1, 32'h0);
        rd_chk("R12 bad", 2'd2, 32'h0);

        for (int i = 0; i < NV; i++) begin
            tlbr = TBL[i].tlbr; adf = TBL[i].adf; st = TBL[i].st; sys = TBL[i].sys;
            irq = TBL[i].irq; eret = TBL[i].eret; rd_en = TBL[i].rd;
            inst_pc = TBL[i].pc; fault_va = TBL[i].va;
            step();
            chk($sformatf("R5 rv vec%0d", i), {31'b0, rv}, {31'b0, TBL[i].rv});
            if (TBL[i].rv) chk($sformatf("R5 rpc vec%0d", i), rpc, TBL[i].rpc);
            chk($sformatf("R2 kernel vec%0d", i), {31'b0, kmode}, {31'b0, TBL[i].k});
            chk($sformatf("R2 ie vec%0d", i), {31'b0, ie}, {31'b0, TBL[i].ie});
        end

        // R7 R1 R3 R4 syscall registers; bad address kept from earlier fault
        sys = 1; inst_pc = 32'h800;
        step();
        rd_chk("R1 epc sys", 2'd0, 32'h800);
        rd_chk("R3 cause sys", 2'd1, 32'h20);
        rd_chk("R4 bad kept", 2'd2, 32'hdeadbeef);
        rd_chk("R7 sel3", 2'd3, 32'h0);

        // R3 R4 store address fault
        eret = 1; step();
        adf = 1; st = 1; inst_pc = 32'h900; fault_va = 32'hcafe0000;
        step();
        rd_chk("R3 cause ades", 2'd1, 32'h14);
        rd_chk("R4 bad ades", 2'd2, 32'hcafe0000);

        // R10 masked interrupt in kernel leaves state alone
        irq = 6'h3f; inst_pc = 32'h950;
        step();
        chk("R10 no redirect", {31'b0, rv}, 32'd0);
        rd_chk("R10 epc kept", 2'd0, 32'h900);

        // R11 syscall overrides a same-cycle return
        eret = 1; sys = 1; inst_pc = 32'ha00;
        step();
        chk("R11 kernel kept", {31'b0, kmode}, 32'd1);
        chk("R11 rpc", rpc, VG);
        rd_chk("R11 epc", 2'd0, 32'ha00);

        // R3 interrupt line snapshot
        eret = 1; step();
        irq = 6'h20; inst_pc = 32'hb00;
        step();
        rd_chk("R3 cause irq", 2'd1, 32'h2000);
        rd_chk("R1 epc irq", 2'd0, 32'hb00);

        // R3 refill on load code
        tlbr = 1; inst_pc = 32'hc00; fault_va = 32'h0000_4000;
        step();
        chk("R5 refill vec", rpc, VR);
        rd_chk("R3 cause tlbl", 2'd1, 32'h8);
        rd_chk("R4 bad tlbl", 2'd2, 32'h0000_4000);

        // R12 reset mid-run
        eret = 1; step();
        rst_n = 1'b0;
        #1;
        chk("R12 kernel again", {31'b0, kmode}, 32'd1);
        chk("R12 ie again", {31'b0, ie}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk("R12 epc again", 2'd0, 32'h0);
        rd_chk("R12 bad again", 2'd2, 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule